// File: doc/BRIEF.md
# Converter Wake-Up and Initialization Sequencer

This block governs the digital side of a stereo audio converter as it leaves and re-enters power-down. While the active-low power-down input is held low, it holds the decimation filter in reset and drives both output samples to zero. Once that input is released, the block waits for the frame clock to show activity. It then spends a fixed number of frames in initialization, with both outputs still zero. Only after that count does it start passing converted samples through, limiting them to the 24-bit two's-complement range.

The block runs on the master clock. The frame (left/right) clock arrives as a level sampled on that master clock. A format input chooses which frame-clock transition begins a frame: the rising one for the left-justified layout, or the falling one for the I2S layout. If the frame clock stops for too long while the block is initializing or running, the block returns to waiting for clocks and repeats the full initialization count.

Top module: `adc_wake_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters power-down: `filt_rst_o` is 1, `ready_o` is 0 and both sample outputs are 0.
- R2: When `pd_n` is low at a clock edge, the block is in power-down after that edge: `filt_rst_o` is 1 and `ready_o` is 0. Both sample outputs are 0 one edge later.
- R3: After `pd_n` returns high, `filt_rst_o` drops one edge later. With no frame-clock transition, `ready_o` and both outputs stay 0 for as long as the frame clock is quiet.
- R4: With `i2s_mode` = 0, the first rising edge of `lrck` after release starts initialization. `ready_o` stays 0 until 4129 (`INIT_FRAMES`) further rising edges have been seen, and it rises on the edge that detects the last of them.
- R5: With `i2s_mode` = 1, only falling edges of `lrck` start and count frames. The same 4129-frame count applies, and rising edges are not counted.
- R6: Whenever `ready_o` is 0, both sample outputs are 0 one edge later, whatever the sample inputs carry.
- R7: While `ready_o` is 1, an input sample inside the signed 24-bit range appears, truncated to its low 24 bits, on the matching output one edge later.
- R8: While `ready_o` is 1, an input above +(2^23-1) is output as 0x7FFFFF, and an input below -2^23 is output as 0x800000, one edge later.
- R9: If no `lrck` transition occurs for `LOSS_LIMIT` (1024) master-clock cycles during initialization or run, the block returns to waiting for clocks: `ready_o` is 0 and the outputs are 0.
- R10: `filt_rst_o` is 1 only in power-down, `ready_o` is 1 only in run, and the two are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_n | input | 1 | Active-low power-down request, synchronous to `clk` |
| lrck | input | 1 | Frame clock level, sampled on `clk` |
| i2s_mode | input | 1 | 0: rising `lrck` edge starts a frame; 1: falling edge does |
| smp_l_i | input | IN_W (28) | Left sample from the filter, signed |
| smp_r_i | input | IN_W (28) | Right sample from the filter, signed |
| smp_l_o | output | OUT_W (24) | Gated, saturated left sample |
| smp_r_o | output | OUT_W (24) | Gated, saturated right sample |
| filt_rst_o | output | 1 | Holds the decimation filter in reset |
| ready_o | output | 1 | High only while samples are passed through |

## Verification
The properties assume that `pd_n`, `lrck` and the sample inputs already belong to the master-clock domain. They do not check metastability, because the block samples these inputs directly. The bench drives every input on the falling clock edge, so each change is seen cleanly at the next rising edge. The frame clock toggles every four master cycles, which keeps it well inside the loss window except when a test deliberately stops it. The format select changes only while the block is held in power-down.

// File: rtl/wake_pkg.sv
// Shared types of the wake-up sequencer.
// Assumes nothing beyond a single master-clock domain.
package wake_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,   // power-down, filter held in reset
        ST_WAIT = 2'd1,   // waiting for frame-clock activity
        ST_INIT = 2'd2,   // counting initialization frames
        ST_RUN  = 2'd3    // samples passed through
    } seq_state_t;

endpackage

// File: rtl/lrck_watch.sv
// Frame-clock observer: finds the frame-start transition chosen by the
// format select, and reports a lost frame clock after LOSS_LIMIT master
// cycles without any transition.
// Assumes lrck is already synchronous to clk.
module lrck_watch #(
    parameter int LOSS_LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lrck,
    input  logic i2s_mode,
    output logic start_edge,
    output logic lrck_lost
);
    localparam int CW = $clog2(LOSS_LIMIT + 1);

    logic          lrck_q;
    logic [CW-1:0] idle_cnt;
    logic          any_edge;

    assign any_edge   = lrck ^ lrck_q;
    assign start_edge = i2s_mode ? (lrck_q & ~lrck) : (~lrck_q & lrck);
    assign lrck_lost  = (idle_cnt == CW'(LOSS_LIMIT));

    // Previous frame-clock level, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lrck_q <= 1'b0;
        else        lrck_q <= lrck;
    end

    // Cycles since the last frame-clock transition, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || any_edge)
            idle_cnt <= '0;
        else if (idle_cnt != CW'(LOSS_LIMIT))
            idle_cnt <= idle_cnt + 1'b1;
    end
endmodule

// File: rtl/wake_fsm.sv
// Power-down / wait / initialize / run controller.
// Power-down overrides every state. Initialization ends on the
// INIT_FRAMES-th frame start after the one that began it.
// Assumes start_edge and lrck_lost come from lrck_watch in the same cycle.
module wake_fsm
    import wake_pkg::*;
#(
    parameter int INIT_FRAMES = 4129
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pd_n,
    input  logic       start_edge,
    input  logic       lrck_lost,
    output seq_state_t state
);
    localparam int FW = $clog2(INIT_FRAMES);

    seq_state_t    state_nx;
    logic [FW-1:0] frame_cnt;
    logic [FW-1:0] frame_cnt_nx;

    // Next state and frame count.
    always_comb begin
        state_nx     = state;
        frame_cnt_nx = frame_cnt;
        if (!pd_n) begin
            state_nx     = ST_OFF;
            frame_cnt_nx = '0;
        end else begin
            unique case (state)
                ST_OFF:  state_nx = ST_WAIT;
                ST_WAIT: if (start_edge) begin
                    state_nx     = ST_INIT;
                    frame_cnt_nx = '0;
                end
                ST_INIT: if (lrck_lost) begin
                    state_nx = ST_WAIT;
                end else if (start_edge) begin
                    if (frame_cnt == FW'(INIT_FRAMES - 1)) state_nx = ST_RUN;
                    else frame_cnt_nx = frame_cnt + 1'b1;
                end
                ST_RUN:  if (lrck_lost) state_nx = ST_WAIT;
                default: state_nx = ST_OFF;
            endcase
        end
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_OFF;
            frame_cnt <= '0;
        end else begin
            state     <= state_nx;
            frame_cnt <= frame_cnt_nx;
        end
    end
endmodule

// File: rtl/sample_gate.sv
// One output channel: limits a wide signed sample to OUT_W bits and
// registers it, or registers zero when not passing.
// Assumes IN_W >= OUT_W.
module sample_gate #(
    parameter int IN_W  = 28,
    parameter int OUT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pass,
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);
    localparam int HEAD = IN_W - OUT_W + 1;
    localparam logic [OUT_W-1:0] POS_LIM = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] NEG_LIM = {1'b1, {(OUT_W-1){1'b0}}};

    logic [HEAD-1:0]  head;
    logic             fits;
    logic [OUT_W-1:0] limited;

    assign head = din[IN_W-1 -: HEAD];
    assign fits = (&head) || !(|head);

    // Saturate out-of-range values to the limit of their sign.
    always_comb begin
        if (fits)              limited = din[OUT_W-1:0];
        else if (din[IN_W-1])  limited = NEG_LIM;
        else                   limited = POS_LIM;
    end

    // Output register, zero unless passing.
    always_ff @(posedge clk) begin
        if (!rst_n || !pass) dout <= '0;
        else                 dout <= limited;
    end
endmodule

// File: rtl/adc_wake_seq.sv
// Top of the wake-up sequencer: frame-clock observer, controller and
// one sample gate per channel.
// Assumes all inputs are synchronous to clk, which is the master clock.
module adc_wake_seq
    import wake_pkg::*;
#(
    parameter int IN_W        = 28,
    parameter int OUT_W       = 24,
    parameter int INIT_FRAMES = 4129,
    parameter int LOSS_LIMIT  = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_n,
    input  logic             lrck,
    input  logic             i2s_mode,
    input  logic [IN_W-1:0]  smp_l_i,
    input  logic [IN_W-1:0]  smp_r_i,
    output logic [OUT_W-1:0] smp_l_o,
    output logic [OUT_W-1:0] smp_r_o,
    output logic             filt_rst_o,
    output logic             ready_o
);
    localparam int NCH = 2;

    seq_state_t       state;
    logic             start_edge;
    logic             lrck_lost;
    logic             run_q;
    logic [IN_W-1:0]  din_a  [NCH];
    logic [OUT_W-1:0] dout_a [NCH];

    lrck_watch #(.LOSS_LIMIT(LOSS_LIMIT)) u_watch (
        .clk        (clk),
        .rst_n      (rst_n),
        .lrck       (lrck),
        .i2s_mode   (i2s_mode),
        .start_edge (start_edge),
        .lrck_lost  (lrck_lost)
    );

    wake_fsm #(.INIT_FRAMES(INIT_FRAMES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pd_n       (pd_n),
        .start_edge (start_edge),
        .lrck_lost  (lrck_lost),
        .state      (state)
    );

    assign run_q      = (state == ST_RUN);
    assign ready_o    = run_q;
    assign filt_rst_o = (state == ST_OFF);

    assign din_a[0] = smp_l_i;
    assign din_a[1] = smp_r_i;
    assign smp_l_o  = dout_a[0];
    assign smp_r_o  = dout_a[1];

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        sample_gate #(.IN_W(IN_W), .OUT_W(OUT_W)) u_gate (
            .clk   (clk),
            .rst_n (rst_n),
            .pass  (run_q),
            .din   (din_a[ch]),
            .dout  (dout_a[ch])
        );
    end
endmodule

// File: rtl/adc_wake_seq_chk.sv
// Checker for adc_wake_seq: relates the control outputs, the power-down
// input and the sample path over time. It is bound into every instance.
module adc_wake_seq_chk #(
    parameter int IN_W  = 28,
    parameter int OUT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pd_n,
    input logic             start_edge,
    input logic             filt_rst_o,
    input logic             ready_o,
    input logic [IN_W-1:0]  smp_l_i,
    input logic [IN_W-1:0]  smp_r_i,
    input logic [OUT_W-1:0] smp_l_o,
    input logic [OUT_W-1:0] smp_r_o
);
    localparam longint HI = (longint'(1) <<< (OUT_W - 1)) - 1;
    localparam longint LO = -(longint'(1) <<< (OUT_W - 1));
    localparam logic [OUT_W-1:0] POS_LIM = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] NEG_LIM = {1'b1, {(OUT_W-1){1'b0}}};

    logic signed [IN_W-1:0] sl;
    logic signed [IN_W-1:0] sr;
    assign sl = smp_l_i;
    assign sr = smp_r_i;

    // R10
    excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready_o && filt_rst_o));

    // R2
    pd_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> (filt_rst_o && !ready_o));

    // R3
    pd_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(filt_rst_o) |-> $past(pd_n));

    // R4
    run_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(start_edge));

    // R6
    zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |=> (smp_l_o == '0 && smp_r_o == '0));

    // R7
    pass_l_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && sl <= HI && sl >= LO) |=> smp_l_o == $past(smp_l_i[OUT_W-1:0]));

    // R8
    sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && sr > HI) |=> smp_r_o == POS_LIM);

    // R8
    sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && sr < LO) |=> smp_r_o == NEG_LIM);
endmodule

bind adc_wake_seq adc_wake_seq_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pd_n       (pd_n),
    .start_edge (start_edge),
    .filt_rst_o (filt_rst_o),
    .ready_o    (ready_o),
    .smp_l_i    (smp_l_i),
    .smp_r_i    (smp_r_i),
    .smp_l_o    (smp_l_o),
    .smp_r_o    (smp_r_o)
);

// File: tb/test_adc_wake_seq.sv
// Directed bench for adc_wake_seq: one task per scenario.
// Inputs change on the falling clock edge; outputs are sampled there too.
module test_adc_wake_seq;
    localparam int IN_W   = 28;
    localparam int OUT_W  = 24;
    localparam int NINIT  = 4129;
    localparam int HALF_F = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pd_n = 1'b0;
    logic             lrck = 1'b0;
    logic             i2s_mode = 1'b0;
    logic [IN_W-1:0]  smp_l_i = '0;
    logic [IN_W-1:0]  smp_r_i = '0;
    logic [OUT_W-1:0] smp_l_o;
    logic [OUT_W-1:0] smp_r_o;
    logic             filt_rst_o;
    logic             ready_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    adc_wake_seq i_adc_wake_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pd_n       (pd_n),
        .lrck       (lrck),
        .i2s_mode   (i2s_mode),
        .smp_l_i    (smp_l_i),
        .smp_r_i    (smp_r_i),
        .smp_l_o    (smp_l_o),
        .smp_r_o    (smp_r_o),
        .filt_rst_o (filt_rst_o),
        .ready_o    (ready_o)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_ctl(input string tag, input bit exp_rst, input bit exp_rdy);
        check(filt_rst_o == exp_rst, {tag, " filt_rst"}, filt_rst_o, exp_rst);
        check(ready_o == exp_rdy, {tag, " ready"}, ready_o, exp_rdy);
    endtask

    task automatic check_zero(input string tag);
        check(smp_l_o == '0, {tag, " left zero"}, smp_l_o, 0);
        check(smp_r_o == '0, {tag, " right zero"}, smp_r_o, 0);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_frames(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); lrck = ~lrck; cycles(HALF_F - 1);
            @(negedge clk); lrck = ~lrck; cycles(HALF_F - 1);
        end
    endtask

    task automatic drive_pair(input logic [IN_W-1:0] l, input logic [IN_W-1:0] r,
                              input logic [OUT_W-1:0] el, input logic [OUT_W-1:0] er,
                              input string tag);
        @(negedge clk);
        smp_l_i = l;
        smp_r_i = r;
        run_frames(1);
        check(smp_l_o == el, {tag, " left"}, smp_l_o, el);
        check(smp_r_o == er, {tag, " right"}, smp_r_o, er);
    endtask

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        cycles(4);
        check_ctl("R1 reset", 1'b1, 1'b0);
        check_zero("R1 reset");
        rst_n = 1'b1;
        cycles(2);
        check_ctl("R2 held down", 1'b1, 1'b0);
    endtask

    // R3: released but frame clock silent
    task automatic t_wait_quiet();
        smp_l_i = 28'h0123456;
        smp_r_i = 28'h0654321;
        pd_n = 1'b1;
        cycles(2);
        check_ctl("R3 released", 1'b0, 1'b0);
        cycles(2000);
        check_ctl("R3 quiet", 1'b0, 1'b0);
        check_zero("R3 quiet");
    endtask

    // R4, R6: left-justified initialization count
    task automatic t_init_lj();
        run_frames(2000);
        check_ctl("R4 mid init", 1'b0, 1'b0);
        check_zero("R6 mid init");
        run_frames(NINIT - 2000);
        check_ctl("R4 before last frame", 1'b0, 1'b0);
        @(negedge clk); lrck = ~lrck;
        @(negedge clk);
        check_ctl("R4 last frame", 1'b0, 1'b1);
        cycles(HALF_F - 2);
        @(negedge clk); lrck = ~lrck; cycles(HALF_F - 1);
    endtask

    // R7, R8: pass-through and limits
    task automatic t_samples();
        drive_pair(28'h0123456, 28'hFFFFFFB, 24'h123456, 24'hFFFFFB, "R7 in range");
        drive_pair(28'h07FFFFF, 28'hF800000, 24'h7FFFFF, 24'h800000, "R7 exact limits");
        drive_pair(28'h0800000, 28'hF7FFFFF, 24'h7FFFFF, 24'h800000, "R8 just outside");
        drive_pair(28'hF000000, 28'h7FFFFFF, 24'h800000, 24'h7FFFFF, "R8 far outside");
    endtask

    // R9: frame clock stops while running
    task automatic t_loss();
        cycles(900);
        check_ctl("R9 before limit", 1'b0, 1'b1);
        cycles(200);
        check_ctl("R9 after limit", 1'b0, 1'b0);
        check_zero("R9 after limit");
    endtask

    // R2, R5: power-down, then I2S initialization on falling edges
    task automatic t_init_i2s();
        pd_n = 1'b0;
        cycles(3);
        check_ctl("R2 power-down", 1'b1, 1'b0);
        i2s_mode = 1'b1;
        lrck = 1'b1;
        cycles(3);
        pd_n = 1'b1;
        cycles(2);
        check_ctl("R3 i2s released", 1'b0, 1'b0);
        run_frames(NINIT);
        check_ctl("R5 before last frame", 1'b0, 1'b0);
        @(negedge clk); lrck = ~lrck;
        @(negedge clk);
        check_ctl("R5 last frame", 1'b0, 1'b1);
        cycles(HALF_F - 2);
        @(negedge clk); lrck = ~lrck; cycles(HALF_F - 1);
        drive_pair(28'h0000001, 28'hFFFFFFF, 24'h000001, 24'hFFFFFF, "R7 i2s");
    endtask

    // R2, R10: power-down while running
    task automatic t_pd_run();
        @(negedge clk); pd_n = 1'b0;
        cycles(3);
        check_ctl("R10 pd in run", 1'b1, 1'b0);
        check_zero("R2 pd in run");
    endtask

    initial begin
        t_reset();
        t_wait_quiet();
        t_init_lj();
        t_samples();
        t_loss();
        t_init_i2s();
        t_pd_run();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule